// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Rewind

This block is a single-clock FIFO whose read behaviour is chosen by a strap input sampled during master reset. In standard mode every word leaves the FIFO only on a requested read, and two flags report "words present" and "space left". In fall-through mode the oldest word is presented on the output with no request. The flags then report "output word valid" and "no space left". The word held in the output register counts toward capacity in this mode.

Two synchronous resets are provided. The master reset also captures the mode strap. The partial reset clears pointers and data but keeps the mode. A rewind request moves the read pointer back to memory location 0, so the words written since the last reset can be replayed. The rewind is followed by a fixed setup interval during which the status flag shows "nothing to read". Three active-low level flags (almost-empty, almost-full and half-full) are derived from the stored word count. The almost-empty and almost-full thresholds are taken from input ports.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst_n` is low on a clock edge, the mode is captured from `ft_strap` (0 = standard, 1 = fall-through). Pointers, the stored count and `dout` are cleared to zero.
- R2: After either reset, `ae_n`=0, `af_n`=1, `hf_n`=1 and `dout`=0. In standard mode `ef_or`=0 and `full_ir`=1. In fall-through mode `ef_or`=1 and `full_ir`=0.
- R3: While `prst_n` is low on a clock edge, the FIFO is cleared as in R1, but the mode does not change, whatever the value of `ft_strap`.
- R4: In standard mode, `ren_n` low on an edge with at least one word stored puts the oldest word on `dout` after that edge. `ef_or` is 1 while words are stored and 0 when none are. A read request on an empty FIFO leaves `dout` unchanged.
- R5: In fall-through mode, a word written into an empty FIFO appears on `dout` one edge after the write edge, with no read request. `ef_or` falls to 0 in the same cycle. Later words reach `dout` only through `ren_n` low.
- R6: In fall-through mode, `ef_or` rises only on an edge with `ren_n` low that consumes the last word. `dout` keeps that word afterwards.
- R7: Capacity is DEPTH words in standard mode and DEPTH+1 in fall-through mode. When full, `full_ir` is 0 in standard mode and 1 in fall-through mode. A write request while full is ignored.
- R8: `rt_n` low on an edge with `ren_n` and `wen_n` both high, outside setup, starts a rewind setup lasting two cycles. During setup `ef_or` is held at 0 (standard) or 1 (fall-through), and read and write requests are ignored.
- R9: After setup, the stored count equals the number of words written since the last reset (valid for 1 to DEPTH-2 words), and reading restarts at location 0. In fall-through mode, location 0 is on `dout` when `ef_or` falls.
- R10: If a rewind request and a fall-through load are due on the same edge, the rewind takes effect and `dout` does not change on that edge.
- R11: Let the level be the stored words, plus the output word in fall-through mode, and let cap be the capacity from R7. Then `ae_n`=0 iff level <= `ae_ofs`, `af_n`=0 iff level >= cap - `af_ofs`, and `hf_n`=0 iff level > DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, synchronous, active low; captures the mode |
| prst_n | input | 1 | Partial reset, synchronous, active low; keeps the mode |
| ft_strap | input | 1 | Mode strap sampled during master reset |
| wen_n | input | 1 | Write request, active low |
| ren_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Rewind request, active low |
| din | input | W | Write data |
| ae_ofs | input | clog2(DEPTH)+1 | Almost-empty threshold |
| af_ofs | input | clog2(DEPTH)+1 | Almost-full distance from capacity |
| dout | output | W | Output register |
| ef_or | output | 1 | Standard: 1 = words present; fall-through: 1 = output not valid |
| full_ir | output | 1 | Standard: 0 = full; fall-through: 1 = full |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
In fall-through mode, a rewind request and the automatic load of the head word can be due on the same edge. The bench provokes this by writing one word into a freshly cleared FIFO and raising the rewind request on the very next edge, while the load is still pending. It judges the outcome by checking that `dout` is still zero after that edge, that `ef_or` stays high for the whole setup, and that the word then appears exactly when `ef_or` falls.

// File: rtl/rf_pkg.sv
// Shared types for the rewind FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rf_pkg;
    typedef enum logic {
        RM_STD  = 1'b0,
        RM_FWFT = 1'b1
    } rmode_e;

    localparam int unsigned SETUP_CYCLES = 2;
endpackage

// File: rtl/rf_store.sv
// Storage array: one synchronous write port, one combinational read port.
// Assumes: DEPTH is a power of two so that the pointers wrap naturally.
module rf_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] cells [DEPTH];

    // Capture write data into the addressed cell.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the cell at the read pointer.
    always_comb begin
        rdata = cells[raddr];
    end
endmodule

// File: rtl/rf_ctrl.sv
// Pointer, count, output-register and rewind-setup control.
// Assumes: synchronous active-low resets, master over partial; DEPTH is a power of two.
module rf_ctrl
    import rf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     mrst_n,
    input  logic                     prst_n,
    input  logic                     ft_strap,
    input  logic                     wen_n,
    input  logic                     ren_n,
    input  logic                     rt_n,
    input  logic [W-1:0]             rd_word,
    output rmode_e                   mode,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_ptr,
    output logic [$clog2(DEPTH)-1:0] rd_ptr,
    output logic [$clog2(DEPTH):0]   mcount,
    output logic                     oval,
    output logic                     busy,
    output logic [$clog2(DEPTH):0]   lvl,
    output logic [W-1:0]             dout
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP_STD = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_FT  = CW'(DEPTH + 1);
    localparam logic [1:0]    SC_INIT = 2'(SETUP_CYCLES);

    rmode_e          mode_q;
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]   mcnt_q;
    logic            oval_q;
    logic [1:0]      sc_q;
    logic [W-1:0]    dout_q;

    logic            is_ft, full, rt_go, wr_do, pop, drain, ld_ft, rd_std;
    logic [CW-1:0]   lvl_c;

    // Derive the per-cycle decisions from the registered state.
    always_comb begin
        is_ft  = (mode_q == RM_FWFT);
        lvl_c  = mcnt_q + CW'(is_ft && oval_q);
        full   = (lvl_c == (is_ft ? CAP_FT : CAP_STD));
        rt_go  = (sc_q == 2'd0) && !rt_n && ren_n && wen_n;
        wr_do  = (sc_q == 2'd0) && !wen_n && !full;
        rd_std = (sc_q == 2'd0) && !ren_n && (mcnt_q != '0);
        ld_ft  = (mcnt_q != '0) &&
                 ((sc_q != 2'd0) ? (sc_q == 2'd1) : (!oval_q || !ren_n));
        pop    = !rt_go && (is_ft ? ld_ft : rd_std);
        drain  = is_ft && (sc_q == 2'd0) && oval_q && !ren_n && (mcnt_q == '0);
    end

    // Capture the read mode from the strap during master reset only.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            mode_q <= rmode_e'(ft_strap);
        end
    end

    // Advance pointers, count, output register and the setup counter.
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            mcnt_q   <= '0;
            oval_q   <= 1'b0;
            sc_q     <= 2'd0;
            dout_q   <= '0;
        end else begin
            if (wr_do) begin
                wr_ptr_q <= wr_ptr_q + AW'(1);
            end
            if (rt_go) begin
                rd_ptr_q <= '0;
                mcnt_q   <= CW'(wr_ptr_q);
                oval_q   <= 1'b0;
                sc_q     <= SC_INIT;
            end else begin
                mcnt_q <= mcnt_q + CW'(wr_do) - CW'(pop);
                if (sc_q != 2'd0) begin
                    sc_q <= sc_q - 2'd1;
                end
                if (pop) begin
                    rd_ptr_q <= rd_ptr_q + AW'(1);
                    dout_q   <= rd_word;
                    oval_q   <= is_ft;
                end else if (drain) begin
                    oval_q <= 1'b0;
                end
            end
        end
    end

    assign mode   = mode_q;
    assign wr_en  = wr_do;
    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;
    assign mcount = mcnt_q;
    assign oval   = oval_q;
    assign busy   = (sc_q != 2'd0);
    assign lvl    = lvl_c;
    assign dout   = dout_q;
endmodule

// File: rtl/rf_flags.sv
// Status and level flags decoded from the control state.
// Assumes: lvl already includes the output word in fall-through mode.
module rf_flags
    import rf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  rmode_e                 mode,
    input  logic [$clog2(DEPTH):0] mcount,
    input  logic                   oval,
    input  logic                   busy,
    input  logic [$clog2(DEPTH):0] lvl,
    input  logic [$clog2(DEPTH):0] ae_ofs,
    input  logic [$clog2(DEPTH):0] af_ofs,
    output logic                   ef_or,
    output logic                   full_ir,
    output logic                   ae_n,
    output logic                   af_n,
    output logic                   hf_n
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW:0] CAP_STD = (CW+1)'(DEPTH);
    localparam logic [CW:0] CAP_FT  = (CW+1)'(DEPTH + 1);
    localparam logic [CW:0] HALF    = (CW+1)'(DEPTH / 2);

    logic [CW:0] cap, lvl_x, reach;

    // Decode the mode-specific status pair and the three level flags.
    always_comb begin
        cap   = (mode == RM_FWFT) ? CAP_FT : CAP_STD;
        lvl_x = {1'b0, lvl};
        reach = lvl_x + {1'b0, af_ofs};
        if (mode == RM_FWFT) begin
            ef_or   = !oval || busy;
            full_ir = (lvl_x == cap);
        end else begin
            ef_or   = (mcount != '0) && !busy;
            full_ir = (lvl_x != cap);
        end
        ae_n = !(lvl_x <= {1'b0, ae_ofs});
        af_n = !(reach >= cap);
        hf_n = !(lvl_x > HALF);
    end
endmodule

// File: rtl/rewind_fifo.sv
// Top: dual-mode single-clock FIFO with rewind and level flags.
// Assumes: DEPTH is a power of two and at least 4; resets are synchronous.
module rewind_fifo
    import rf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   mrst_n,
    input  logic                   prst_n,
    input  logic                   ft_strap,
    input  logic                   wen_n,
    input  logic                   ren_n,
    input  logic                   rt_n,
    input  logic [W-1:0]           din,
    input  logic [$clog2(DEPTH):0] ae_ofs,
    input  logic [$clog2(DEPTH):0] af_ofs,
    output logic [W-1:0]           dout,
    output logic                   ef_or,
    output logic                   full_ir,
    output logic                   ae_n,
    output logic                   af_n,
    output logic                   hf_n
);
    localparam int AW = $clog2(DEPTH);

    rmode_e          mode;
    logic            wr_en, oval, busy;
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [AW:0]     mcount, lvl;
    logic [W-1:0]    rd_word;

    rf_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_ptr),
        .rdata (rd_word)
    );

    rf_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .ft_strap (ft_strap),
        .wen_n    (wen_n),
        .ren_n    (ren_n),
        .rt_n     (rt_n),
        .rd_word  (rd_word),
        .mode     (mode),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .mcount   (mcount),
        .oval     (oval),
        .busy     (busy),
        .lvl      (lvl),
        .dout     (dout)
    );

    rf_flags #(.DEPTH(DEPTH)) u_flags (
        .mode    (mode),
        .mcount  (mcount),
        .oval    (oval),
        .busy    (busy),
        .lvl     (lvl),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs),
        .ef_or   (ef_or),
        .full_ir (full_ir),
        .ae_n    (ae_n),
        .af_n    (af_n),
        .hf_n    (hf_n)
    );
endmodule

// File: rtl/rf_checker.sv
// Temporal checks on the rewind FIFO, attached to every instance by bind.
// Assumes: resets are synchronous and active low.
module rf_checker
    import rf_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input logic                     clk,
    input logic                     mrst_n,
    input logic                     prst_n,
    input logic                     wen_n,
    input logic                     ren_n,
    input logic                     rt_n,
    input rmode_e                   mode,
    input logic                     busy,
    input logic                     oval,
    input logic [$clog2(DEPTH)-1:0] wr_ptr,
    input logic [$clog2(DEPTH):0]   lvl,
    input logic [W-1:0]             dout,
    input logic                     ef_or
);
    localparam int CW = $clog2(DEPTH) + 1;

    // R7: the level never exceeds the capacity of the current mode.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        lvl <= ((mode == RM_FWFT) ? CW'(DEPTH + 1) : CW'(DEPTH)));

    // R4: a read request on an empty standard-mode FIFO leaves the output alone.
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (mode == RM_STD && lvl == '0 && !busy && !ren_n) |=> $stable(dout));

    // R8: the status flag shows "nothing to read" throughout setup.
    assert_setup_flag_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        busy |-> (ef_or == (mode == RM_FWFT)));

    // R8: writes are ignored during setup.
    assert_setup_nowrite_R8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        busy |=> $stable(wr_ptr));

    // R6: outside setup, output-ready rises only after a true read.
    assert_or_rise_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        ($past(mrst_n) && $past(prst_n) && mode == RM_FWFT && !busy && $rose(ef_or))
        |-> ($past(!ren_n) && !oval));

    // R10: the edge that starts a rewind does not change the output word.
    assert_rewind_holds_R10: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (!busy && !rt_n && ren_n && wen_n) |=> $stable(dout));
endmodule

bind rewind_fifo rf_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .mrst_n (mrst_n),
    .prst_n (prst_n),
    .wen_n  (wen_n),
    .ren_n  (ren_n),
    .rt_n   (rt_n),
    .mode   (mode),
    .busy   (busy),
    .oval   (oval),
    .wr_ptr (wr_ptr),
    .lvl    (lvl),
    .dout   (dout),
    .ef_or  (ef_or)
);

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;
    localparam int W = 8;
    localparam int D = 8;
    localparam int CW = $clog2(D) + 1;
    localparam int AEO = 2;
    localparam int AFO = 2;

    logic clk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, ft_strap = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [CW-1:0] ae_ofs = CW'(AEO), af_ofs = CW'(AFO);
    logic [W-1:0] dout;
    logic ef_or, full_ir, ae_n, af_n, hf_n;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rewind_fifo #(.W(W), .DEPTH(D)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ft_strap(ft_strap),
        .wen_n(wen_n), .ren_n(ren_n), .rt_n(rt_n), .din(din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout), .ef_or(ef_or),
        .full_ir(full_ir), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    // Drive one cycle's requests at a falling edge, return at the next one.
    task automatic cyc(input bit w, input bit r, input bit t, input logic [W-1:0] d);
        wen_n = !w; ren_n = !r; rt_n = !t; din = d;
        @(negedge clk);
        wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1;
    endtask

    task automatic mreset(input bit strap);
        mrst_n = 1'b0; ft_strap = strap;
        cyc(0, 0, 0, '0);
        mrst_n = 1'b1; ft_strap = 1'b0;
    endtask

    task automatic preset(input bit strap);
        prst_n = 1'b0; ft_strap = strap;
        cyc(0, 0, 0, '0);
        prst_n = 1'b1; ft_strap = 1'b0;
    endtask

    // R11 level flags for a known level and capacity.
    task automatic lvl_chk(input int k, input int cap, input string tag);
        eq({"R11 ae_n ", tag}, ae_n, (k <= AEO) ? 0 : 1);
        eq({"R11 af_n ", tag}, af_n, (k >= cap - AFO) ? 0 : 1);
        eq({"R11 hf_n ", tag}, hf_n, (k > D / 2) ? 0 : 1);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        // R1 R2: master reset into standard mode.
        @(negedge clk);
        mrst_n = 1'b1;
        eq("R2 std ef_or", ef_or, 0);
        eq("R2 std full_ir", full_ir, 1);
        eq("R2 dout", dout, 0);
        lvl_chk(0, D, "reset");

        // R4 R7 R11: standard fill to capacity.
        for (int k = 1; k <= D; k++) begin
            cyc(1, 0, 0, W'(8'h10 + k - 1));
            eq("R4 ef_or fill", ef_or, 1);
            eq("R7 full_ir fill", full_ir, (k == D) ? 0 : 1);
            lvl_chk(k, D, "std fill");
        end
        cyc(1, 0, 0, 8'hEE);
        eq("R7 std write at full", full_ir, 0);
        for (int i = 0; i < D; i++) begin
            cyc(0, 1, 0, '0);
            eq("R4 std read data", dout, 8'h10 + i);
            eq("R4 ef_or drain", ef_or, (i == D - 1) ? 0 : 1);
            lvl_chk(D - 1 - i, D, "std drain");
        end
        cyc(0, 1, 0, '0);
        eq("R4 empty read keeps dout", dout, 8'h17);
        eq("R4 empty ef_or", ef_or, 0);

        // R4: read and write on the same edge.
        cyc(1, 0, 0, 8'h30);
        cyc(1, 0, 0, 8'h31);
        cyc(1, 1, 0, 8'h32);
        eq("R4 rw same edge data", dout, 8'h30);
        lvl_chk(2, D, "rw");
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        eq("R4 rw tail", dout, 8'h32);
        eq("R4 rw empty", ef_or, 0);

        // R3 R8 R9: partial reset in standard mode, then rewind.
        preset(1'b1);
        eq("R3 std kept ef_or", ef_or, 0);
        eq("R3 std kept full_ir", full_ir, 1);
        eq("R3 dout cleared", dout, 0);
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, W'(8'h40 + k));
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        eq("R4 pre-rewind data", dout, 8'h41);
        cyc(0, 0, 1, '0);
        eq("R8 std setup flag a", ef_or, 0);
        cyc(1, 0, 0, 8'h99);
        eq("R8 std setup flag b", ef_or, 0);
        cyc(0, 1, 0, '0);
        eq("R9 std setup done", ef_or, 1);
        eq("R8 read ignored in setup", dout, 8'h41);
        lvl_chk(5, D, "std rewind");
        for (int i = 0; i < 5; i++) begin
            cyc(0, 1, 0, '0);
            eq("R9 std replay data", dout, 8'h40 + i);
        end
        eq("R9 R8 write ignored, empty after replay", ef_or, 0);

        // R1 R2: master reset into fall-through mode.
        mreset(1'b1);
        eq("R2 ft ef_or", ef_or, 1);
        eq("R2 ft full_ir", full_ir, 0);
        eq("R2 ft dout", dout, 0);
        lvl_chk(0, D + 1, "ft reset");

        // R5 R6 R7 R11: fall-through fill and drain.
        cyc(1, 0, 0, 8'h50);
        eq("R5 not yet valid", ef_or, 1);
        cyc(0, 0, 0, '0);
        eq("R5 fall-through flag", ef_or, 0);
        eq("R5 fall-through data", dout, 8'h50);
        lvl_chk(1, D + 1, "ft one");
        for (int k = 2; k <= D + 1; k++) begin
            cyc(1, 0, 0, W'(8'h50 + k - 1));
            eq("R5 head held without read", dout, 8'h50);
            eq("R7 ft full_ir", full_ir, (k == D + 1) ? 1 : 0);
            lvl_chk(k, D + 1, "ft fill");
        end
        cyc(1, 0, 0, 8'hEE);
        eq("R7 ft write at full", full_ir, 1);
        for (int i = 1; i <= D; i++) begin
            cyc(0, 1, 0, '0);
            eq("R5 ft read data", dout, 8'h50 + i);
            eq("R6 ft still valid", ef_or, 0);
        end
        cyc(0, 1, 0, '0);
        eq("R6 last read flag", ef_or, 1);
        eq("R6 last word kept", dout, 8'h58);
        cyc(0, 1, 0, '0);
        eq("R6 empty read keeps dout", dout, 8'h58);

        // R8 R9: rewind in fall-through mode.
        mreset(1'b1);
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, W'(8'h60 + k));
        eq("R5 head after burst", dout, 8'h60);
        cyc(0, 1, 0, '0);
        cyc(0, 1, 0, '0);
        eq("R5 ft pre-rewind", dout, 8'h62);
        cyc(0, 0, 1, '0);
        eq("R8 ft setup flag a", ef_or, 1);
        eq("R8 ft dout held", dout, 8'h62);
        cyc(0, 0, 0, '0);
        eq("R8 ft setup flag b", ef_or, 1);
        cyc(0, 0, 0, '0);
        eq("R9 ft ready after setup", ef_or, 0);
        eq("R9 ft location 0", dout, 8'h60);
        lvl_chk(4, D + 1, "ft rewind");
        for (int i = 1; i < 4; i++) begin
            cyc(0, 1, 0, '0);
            eq("R9 ft replay data", dout, 8'h60 + i);
        end
        cyc(0, 1, 0, '0);
        eq("R9 ft replay end flag", ef_or, 1);

        // R3 R10: partial reset keeps fall-through; rewind collides with load.
        preset(1'b0);
        eq("R3 ft kept ef_or", ef_or, 1);
        eq("R3 ft kept full_ir", full_ir, 0);
        cyc(1, 0, 0, 8'h70);
        cyc(0, 0, 1, '0);
        eq("R10 dout unchanged", dout, 0);
        eq("R10 flag held", ef_or, 1);
        cyc(0, 0, 0, '0);
        eq("R10 setup flag", ef_or, 1);
        cyc(0, 0, 0, '0);
        eq("R10 load after setup", dout, 8'h70);
        eq("R3 R10 ready", ef_or, 0);
        cyc(0, 1, 0, '0);
        eq("R6 single word consumed", ef_or, 1);

        report();
    end
endmodule